// File: doc/BRIEF.md
# Ingress Transfer Word Decoder and Port Dispatcher

This block sits behind the lane alignment stage of a packet ingress interface. Each cycle it may take one aligned 16-bit word and a control-indicator bit. Words with the indicator set are control words and words with it clear are data words. Control words either open a burst for a logical port (payload control) or close it (idle control). Every control word also reports in its end-status field how the burst before it ended. The block enforces the ordering rules between payload control words and data. It reports reserved control codes and ordering violations as bus-error pulses.

The 8-bit port address of each payload control word is looked up in a 256-entry map that software fills through a simple write port. Each entry holds an active flag and a local ID. Data for an active port is dispatched with the local ID and with start, end, byte-length and packet-error markers. Data for an inactive port is dropped. Each dropped word raises an inactive-transfer pulse, and the port number is held in a sticky register until it is cleared. Each data word is held back until the next valid word arrives, because only the following control word can say whether that data word ended the packet. An abort status taints the next packet that is dispatched.

Control word layout used throughout: bit 15 = payload (1) or idle (0); bits [14:13] = end status of the preceding burst (00 none, 01 abort, 10 end with two valid bytes, 11 end with one valid byte); bit 12 = start of packet; bits [11:4] = port address; bits [3:0] are ignored here.

Top module: `xfer_dispatch`

## Requirements
- R1: A word with `in_vld`=1 and `in_ctl`=0 inside an open burst for an active port is emitted unchanged on `out_data`. `out_vld` is high for exactly one cycle, right after the clock edge that samples the next valid word of the stream. Cycles with `in_vld`=0 do not advance the stream.
- R2: A control word with bit 15 = 0 and bit 12 = 1 (top nibble 0001, 0011, 0101 or 0111) is reserved. It gives a one-cycle `ev_bus_err` pulse in the cycle after it is sampled and otherwise leaves the burst state untouched.
- R3: A payload control word whose next valid word is a control word (payload or idle) gives an `ev_bus_err` pulse in the cycle after that second word is sampled.
- R4: A data word that arrives with no open burst (no payload control word before it, or the burst was already closed) gives an `ev_bus_err` pulse and is dropped.
- R5: Bits [11:4] of a payload control word select a map entry. Every word of that burst is dispatched with the entry's local ID on `out_lid`.
- R6: `out_sop` marks the first dispatched word after a payload control word with bit 12 = 1. `out_eop` marks a word released by a control word whose end status is 01, 10 or 11.
- R7: `out_len` is the byte count of the current packet up to and including the emitted word. It adds 2 per word, or 1 when the word ends with status 11, and restarts with the word that carries `out_sop`.
- R8: An end status of 01 (abort) sets `out_err` on every word of the next packet that starts with `out_sop`. The packet after that one is clean again.
- R9: A data word in a burst whose map entry is inactive is dropped. It gives a one-cycle `ev_inactive` pulse, sets `inact_vld`, and loads the burst's port address into `inact_port` in that same cycle.
- R10: `inact_vld` and `inact_port` hold their value until `inact_clr` is sampled high, which clears both to 0 in the next cycle. A new inactive event in that same cycle wins over the clear.
- R11: A write with `map_we`=1 updates the entry at `map_port`. It applies to payload control words sampled on later clock edges, and bursts already open keep the entry they looked up.
- R12: After reset all outputs are 0 and every map entry is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input word present |
| in_ctl | input | 1 | 1 = control word, 0 = data word |
| in_word | input | 16 | Aligned ingress word |
| map_we | input | 1 | Map entry write strobe |
| map_port | input | 8 | Map entry index (logical port) |
| map_active | input | 1 | Active flag to write |
| map_lid | input | LID_W | Local ID to write |
| inact_clr | input | 1 | Clears the held inactive-port record |
| out_vld | output | 1 | Dispatched word valid |
| out_data | output | 16 | Dispatched data word |
| out_sop | output | 1 | First word of a packet |
| out_eop | output | 1 | Last word of a packet |
| out_len | output | LEN_W | Packet bytes so far, including this word |
| out_err | output | 1 | Packet is tainted by an earlier abort |
| out_lid | output | LID_W | Local ID of the destination |
| ev_bus_err | output | 1 | Protocol violation pulse |
| ev_inactive | output | 1 | Dropped word to an inactive port pulse |
| inact_vld | output | 1 | Inactive-port record is held |
| inact_port | output | 8 | Port address of the last inactive transfer |

## Verification
The error and inactive pulses appear in the cycle after the offending word is sampled. The held port record changes in that same cycle. A data word appears only after the edge that samples the next valid word, so its timing depends on how many idle cycles follow it. A map write applies to control words sampled from the next edge on. The bench drives inputs on the falling edge and runs a behavioural model of these rules alongside the design. The model works out what the design should show after the coming rising edge, and the bench compares that on the following falling edge of every cycle. Held-back words, idle gaps and table writes are therefore checked in the exact cycle the rules place them.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int WORD_W = 16;
  localparam int PORT_W = 8;

  typedef enum logic [1:0] {
    END_NONE  = 2'b00,
    END_ABORT = 2'b01,
    END_TWO   = 2'b10,
    END_ONE   = 2'b11
  } end_code_e;

  typedef struct packed {
    logic              is_data;
    logic              is_pay;
    logic              is_idle;
    logic              is_rsvd;
    logic              sop;
    end_code_e         code;
    logic [PORT_W-1:0] port;
  } word_info_t;
endpackage

// File: rtl/xfer_word_decode.sv
module xfer_word_decode
  import xfer_pkg::*;
(
  input  logic              vld,
  input  logic              ctl,
  input  logic [WORD_W-1:0] word,
  output word_info_t        info
);
  logic is_ctl;

  always_comb begin
    is_ctl       = vld & ctl;
    info.is_data = vld & ~ctl;
    info.is_pay  = is_ctl & word[15];
    info.is_rsvd = is_ctl & ~word[15] & word[12];
    info.is_idle = is_ctl & ~word[15] & ~word[12];
    info.sop     = word[12];
    info.code    = end_code_e'(word[14:13]);
    info.port    = word[11:4];
  end
endmodule

// File: rtl/xfer_port_map.sv
module xfer_port_map
  import xfer_pkg::*;
#(
  parameter int LID_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PORT_W-1:0] waddr,
  input  logic              wact,
  input  logic [LID_W-1:0]  wlid,
  input  logic [PORT_W-1:0] raddr,
  output logic              ract,
  output logic [LID_W-1:0]  rlid
);
  localparam int DEPTH = 1 << PORT_W;

  logic [DEPTH-1:0] act_q;
  logic [LID_W-1:0] lid_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (we) begin
      act_q[waddr] <= wact;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      lid_q[waddr] <= wlid;
    end
  end

  assign ract = act_q[raddr];
  assign rlid = lid_q[raddr];
endmodule

// File: rtl/xfer_port_latch.sv
module xfer_port_latch #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic [PW-1:0] hit_port,
  input  logic          clr,
  output logic          held,
  output logic [PW-1:0] held_port
);
  logic          held_d;
  logic [PW-1:0] port_d;

  always_comb begin
    held_d = held;
    port_d = held_port;
    if (hit) begin
      held_d = 1'b1;
      port_d = hit_port;
    end else if (clr) begin
      held_d = 1'b0;
      port_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held      <= 1'b0;
      held_port <= '0;
    end else begin
      held      <= held_d;
      held_port <= port_d;
    end
  end
endmodule

// File: rtl/xfer_burst_ctl.sv
module xfer_burst_ctl
  import xfer_pkg::*;
#(
  parameter int LID_W = 6,
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  word_info_t        info,
  input  logic [WORD_W-1:0] word,
  input  logic              map_act,
  input  logic [LID_W-1:0]  map_lid,
  output logic              o_vld,
  output logic [WORD_W-1:0] o_data,
  output logic              o_sop,
  output logic              o_eop,
  output logic [LEN_W-1:0]  o_len,
  output logic              o_err,
  output logic [LID_W-1:0]  o_lid,
  output logic              o_bus,
  output logic              o_inact,
  output logic              drop_hit,
  output logic [PORT_W-1:0] drop_port
);
  // burst state
  logic              exp_q, exp_d;
  logic              burst_q, burst_d;
  logic              act_q;
  logic [LID_W-1:0]  lid_q;
  logic [PORT_W-1:0] port_q;
  logic              sop_q, sop_d;
  logic              abort_q, abort_d;
  logic              perr_q, perr_d;
  logic [LEN_W-1:0]  len_q, len_d;
  // held-back word
  logic              pv_q, pv_d;
  logic [WORD_W-1:0] pd_q;
  logic              ps_q, pe_q;
  logic [LID_W-1:0]  pl_q;
  // per-cycle decisions
  logic              cap, ld, rel, rel_eop, rel_one, bus_d, inact_d, new_err;
  logic [LEN_W-1:0]  len_step, len_sum;

  always_comb begin
    exp_d   = exp_q;
    burst_d = burst_q;
    sop_d   = sop_q;
    abort_d = abort_q;
    perr_d  = perr_q;
    pv_d    = pv_q;
    cap     = 1'b0;
    ld      = 1'b0;
    rel     = 1'b0;
    rel_eop = 1'b0;
    rel_one = 1'b0;
    bus_d   = 1'b0;
    inact_d = 1'b0;
    new_err = perr_q;
    if (info.is_rsvd) begin
      bus_d = 1'b1;
    end else if (info.is_pay || info.is_idle) begin
      bus_d   = exp_q;
      rel     = pv_q;
      rel_eop = pv_q && (info.code != END_NONE);
      rel_one = pv_q && (info.code == END_ONE);
      pv_d    = 1'b0;
      burst_d = 1'b0;
      if (info.code == END_ABORT) begin
        abort_d = 1'b1;
      end
      exp_d = info.is_pay;
      if (info.is_pay) begin
        cap   = 1'b1;
        sop_d = info.sop;
      end
    end else if (info.is_data) begin
      if (exp_q || burst_q) begin
        exp_d   = 1'b0;
        burst_d = 1'b1;
        if (act_q) begin
          rel   = pv_q;
          ld    = 1'b1;
          pv_d  = 1'b1;
          sop_d = 1'b0;
          if (sop_q) begin
            new_err = abort_q;
            perr_d  = abort_q;
            abort_d = 1'b0;
          end
        end else begin
          inact_d = 1'b1;
        end
      end else begin
        bus_d = 1'b1;
      end
    end
  end

  always_comb begin
    len_step = rel_one ? LEN_W'(1) : LEN_W'(2);
    len_sum  = (ps_q ? '0 : len_q) + len_step;
    len_d    = rel ? len_sum : len_q;
  end

  assign drop_hit  = inact_d;
  assign drop_port = port_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q   <= 1'b0;
      burst_q <= 1'b0;
      sop_q   <= 1'b0;
      abort_q <= 1'b0;
      perr_q  <= 1'b0;
      pv_q    <= 1'b0;
      len_q   <= '0;
    end else begin
      exp_q   <= exp_d;
      burst_q <= burst_d;
      sop_q   <= sop_d;
      abort_q <= abort_d;
      perr_q  <= perr_d;
      pv_q    <= pv_d;
      len_q   <= len_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      lid_q  <= '0;
      port_q <= '0;
    end else if (cap) begin
      act_q  <= map_act;
      lid_q  <= map_lid;
      port_q <= info.port;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q <= 1'b0;
      pe_q <= 1'b0;
      pl_q <= '0;
    end else if (ld) begin
      ps_q <= sop_q;
      pe_q <= new_err;
      pl_q <= lid_q;
    end
  end

  always_ff @(posedge clk) begin
    if (ld) begin
      pd_q <= word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_vld   <= 1'b0;
      o_sop   <= 1'b0;
      o_eop   <= 1'b0;
      o_bus   <= 1'b0;
      o_inact <= 1'b0;
      o_data  <= '0;
      o_len   <= '0;
      o_err   <= 1'b0;
      o_lid   <= '0;
    end else begin
      o_vld   <= rel;
      o_sop   <= rel & ps_q;
      o_eop   <= rel_eop;
      o_bus   <= bus_d;
      o_inact <= inact_d;
      if (rel) begin
        o_data <= pd_q;
        o_len  <= len_sum;
        o_err  <= pe_q;
        o_lid  <= pl_q;
      end
    end
  end
endmodule

// File: rtl/xfer_dispatch.sv
module xfer_dispatch
  import xfer_pkg::*;
#(
  parameter int LID_W = 6,
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic              in_ctl,
  input  logic [15:0]       in_word,
  input  logic              map_we,
  input  logic [7:0]        map_port,
  input  logic              map_active,
  input  logic [LID_W-1:0]  map_lid,
  input  logic              inact_clr,
  output logic              out_vld,
  output logic [15:0]       out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic [LEN_W-1:0]  out_len,
  output logic              out_err,
  output logic [LID_W-1:0]  out_lid,
  output logic              ev_bus_err,
  output logic              ev_inactive,
  output logic              inact_vld,
  output logic [7:0]        inact_port
);
  word_info_t        info;
  logic              lut_act;
  logic [LID_W-1:0]  lut_lid;
  logic              drop_hit;
  logic [PORT_W-1:0] drop_port;

  xfer_word_decode u_dec (
    .vld  (in_vld),
    .ctl  (in_ctl),
    .word (in_word),
    .info (info)
  );

  xfer_port_map #(.LID_W(LID_W)) u_map (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (map_we),
    .waddr (map_port),
    .wact  (map_active),
    .wlid  (map_lid),
    .raddr (info.port),
    .ract  (lut_act),
    .rlid  (lut_lid)
  );

  xfer_burst_ctl #(.LID_W(LID_W), .LEN_W(LEN_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .info      (info),
    .word      (in_word),
    .map_act   (lut_act),
    .map_lid   (lut_lid),
    .o_vld     (out_vld),
    .o_data    (out_data),
    .o_sop     (out_sop),
    .o_eop     (out_eop),
    .o_len     (out_len),
    .o_err     (out_err),
    .o_lid     (out_lid),
    .o_bus     (ev_bus_err),
    .o_inact   (ev_inactive),
    .drop_hit  (drop_hit),
    .drop_port (drop_port)
  );

  xfer_port_latch #(.PW(PORT_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (drop_hit),
    .hit_port  (drop_port),
    .clr       (inact_clr),
    .held      (inact_vld),
    .held_port (inact_port)
  );
endmodule

// File: rtl/xfer_dispatch_chk.sv
module xfer_dispatch_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inact_clr,
  input logic             out_vld,
  input logic             out_sop,
  input logic             out_eop,
  input logic [LEN_W-1:0] out_len,
  input logic             ev_bus_err,
  input logic             ev_inactive,
  input logic             inact_vld,
  input logic [7:0]       inact_port
);
  // R2 R3 R4: a protocol error never coincides with a dispatched word
  a_r2_err_no_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_err |-> !out_vld);

  // R9: a dropped word never coincides with a dispatched word
  a_r9_drop_no_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
    ev_inactive |-> !out_vld && inact_vld);

  // R10: the held record only moves on an event or after a clear
  a_r10_record_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_inactive && !$past(inact_clr)) |-> ($stable(inact_port) && $stable(inact_vld)));

  // R6: packet markers only on dispatched words
  a_r6_markers_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> !out_sop && !out_eop);

  // R7: every dispatched word carries at least one byte
  a_r7_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> out_len != '0);
endmodule

bind xfer_dispatch xfer_dispatch_chk #(.LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .inact_clr   (inact_clr),
  .out_vld     (out_vld),
  .out_sop     (out_sop),
  .out_eop     (out_eop),
  .out_len     (out_len),
  .ev_bus_err  (ev_bus_err),
  .ev_inactive (ev_inactive),
  .inact_vld   (inact_vld),
  .inact_port  (inact_port)
);

// File: tb/xfer_dispatch_tb.sv
module xfer_dispatch_tb;
  localparam int LID_W = 6;
  localparam int LEN_W = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_vld, in_ctl, map_we, map_active, inact_clr;
  logic [15:0]      in_word;
  logic [7:0]       map_port;
  logic [LID_W-1:0] map_lid;
  logic             out_vld, out_sop, out_eop, out_err, ev_bus_err, ev_inactive, inact_vld;
  logic [15:0]      out_data;
  logic [LEN_W-1:0] out_len;
  logic [LID_W-1:0] out_lid;
  logic [7:0]       inact_port;

  always #10 clk = ~clk;

  xfer_dispatch #(.LID_W(LID_W), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_ctl(in_ctl), .in_word(in_word),
    .map_we(map_we), .map_port(map_port), .map_active(map_active), .map_lid(map_lid),
    .inact_clr(inact_clr), .out_vld(out_vld), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop), .out_len(out_len), .out_err(out_err), .out_lid(out_lid),
    .ev_bus_err(ev_bus_err), .ev_inactive(ev_inactive), .inact_vld(inact_vld),
    .inact_port(inact_port)
  );

  int nchk = 0;
  int nerr = 0;

  // reference model state
  typedef struct {
    logic [15:0] d;
    bit          sop;
    int          lid;
    bit          err;
  } held_t;
  held_t held_q[$];
  bit  map_a[256];
  int  map_l[256];
  bit  m_exp, m_burst, m_act, m_sop, m_abort, m_perr;
  int  m_lid, m_port, m_len;
  bit  m_hv;
  int  m_hp;
  // expected outputs after the coming edge
  bit          e_vld, e_sop, e_eop, e_err, e_bus, e_inact;
  logic [15:0] e_data;
  int          e_len, e_lid;
  string       e_bus_req = "R2";
  logic [15:0] dcnt = 16'h1000;

  function automatic void chk(string req, string what, longint got, longint exp);
    nchk++;
    if (got != exp) begin
      nerr++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endfunction

  function automatic logic [15:0] cw(bit pay, logic [1:0] code, bit sop, logic [7:0] port);
    return {pay, code, sop, port, 4'h0};
  endfunction

  function automatic void release_word(bit eop, bit one);
    held_t h = held_q.pop_front();
    m_len  = (h.sop ? 0 : m_len) + (one ? 1 : 2);
    e_vld  = 1; e_data = h.d; e_sop = h.sop; e_eop = eop;
    e_len  = m_len; e_err = h.err; e_lid = h.lid;
  endfunction

  function automatic void model();
    bit ctl_v = in_vld && in_ctl;
    e_vld = 0; e_sop = 0; e_eop = 0; e_bus = 0; e_inact = 0;
    if (ctl_v && !in_word[15] && in_word[12]) begin
      e_bus = 1; e_bus_req = "R2";
    end else if (ctl_v) begin
      if (m_exp) begin e_bus = 1; e_bus_req = "R3"; end
      if (held_q.size() > 0) release_word(in_word[14:13] != 2'b00, in_word[14:13] == 2'b11);
      if (in_word[14:13] == 2'b01) m_abort = 1;
      m_burst = 0;
      m_exp   = in_word[15];
      if (in_word[15]) begin
        m_port = int'(in_word[11:4]);
        m_act  = map_a[m_port];
        m_lid  = map_l[m_port];
        m_sop  = in_word[12];
      end
    end else if (in_vld) begin
      if (m_exp || m_burst) begin
        m_exp = 0; m_burst = 1;
        if (m_act) begin
          held_t h;
          if (held_q.size() > 0) release_word(0, 0);
          if (m_sop) begin m_perr = m_abort; m_abort = 0; end
          h.d = in_word; h.sop = m_sop; h.lid = m_lid; h.err = m_perr;
          held_q.push_back(h);
          m_sop = 0;
        end else begin
          e_inact = 1; m_hv = 1; m_hp = m_port;
        end
      end else begin
        e_bus = 1; e_bus_req = "R4";
      end
    end
    if (!e_inact && inact_clr) begin m_hv = 0; m_hp = 0; end
    if (map_we) begin map_a[map_port] = map_active; map_l[map_port] = int'(map_lid); end
  endfunction

  function automatic void compare();
    chk("R1", "out_vld", out_vld, e_vld);
    if (e_vld) begin
      chk("R1", "out_data", out_data, e_data);
      chk("R5", "out_lid", out_lid, e_lid);
      chk("R6", "out_sop", out_sop, e_sop);
      chk("R6", "out_eop", out_eop, e_eop);
      chk("R7", "out_len", out_len, e_len);
      chk("R8", "out_err", out_err, e_err);
    end
    chk(e_bus_req, "ev_bus_err", ev_bus_err, e_bus);
    chk("R9", "ev_inactive", ev_inactive, e_inact);
    chk("R10", "inact_vld", inact_vld, m_hv);
    chk("R10", "inact_port", inact_port, m_hp);
  endfunction

  task automatic drive(bit v, bit c, logic [15:0] w, bit we = 0, logic [7:0] wp = 0,
                       bit wa = 0, logic [LID_W-1:0] wl = 0, bit clr = 0);
    @(negedge clk);
    compare();
    in_vld = v; in_ctl = c; in_word = w;
    map_we = we; map_port = wp; map_active = wa; map_lid = wl; inact_clr = clr;
    model();
  endtask

  task automatic dw();
    dcnt = dcnt + 16'h0111;
    drive(1, 0, dcnt);
  endtask

  task automatic gap();
    drive(0, 0, 16'h0);
  endtask

  task automatic ctl(bit pay, logic [1:0] code, bit sop, logic [7:0] port);
    drive(1, 1, cw(pay, code, sop, port));
  endtask

  task automatic wr(logic [7:0] p, bit a, logic [LID_W-1:0] l);
    drive(0, 0, 16'h0, 1, p, a, l);
  endtask

  bit done = 0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL R1 watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_vld = 0; in_ctl = 0; in_word = 0; map_we = 0; map_port = 0;
    map_active = 0; map_lid = 0; inact_clr = 0;
    foreach (map_a[i]) begin map_a[i] = 0; map_l[i] = 0; end
    m_exp = 0; m_burst = 0; m_act = 0; m_sop = 0; m_abort = 0; m_perr = 0;
    m_lid = 0; m_port = 0; m_len = 0; m_hv = 0; m_hp = 0;
    e_vld = 0; e_sop = 0; e_eop = 0; e_err = 0; e_bus = 0; e_inact = 0;
    e_data = 0; e_len = 0; e_lid = 0;
    repeat (3) @(negedge clk);
    // R12: outputs quiet in reset
    chk("R12", "out_vld", out_vld, 0);
    chk("R12", "out_sop/eop/err", {out_sop, out_eop, out_err}, 0);
    chk("R12", "out_len", out_len, 0);
    chk("R12", "events", {ev_bus_err, ev_inactive}, 0);
    chk("R12", "inact record", {inact_vld, inact_port}, 0);
    rst_n = 1;

    // R4: stray data with no burst open
    dw();
    // R12 R9: map starts inactive, so this traffic is dropped
    ctl(1, 2'b00, 1, 8'h05); dw(); dw(); ctl(0, 2'b10, 0, 8'h00);
    // R11: fill a few entries
    wr(8'h21, 1, 6'd9); wr(8'h42, 1, 6'd3); wr(8'h07, 0, 6'd12); wr(8'hFF, 1, 6'd63);
    // R1 R6 R7: plain packet ending with two bytes
    ctl(1, 2'b00, 1, 8'h21); dw(); dw(); dw(); ctl(0, 2'b10, 0, 8'h00);
    // R1 R7: idle gaps, single byte end
    ctl(1, 2'b00, 1, 8'h42); gap(); dw(); gap(); gap(); dw(); gap(); ctl(0, 2'b11, 0, 8'h00);
    // R7: packet continued over two bursts
    ctl(1, 2'b00, 1, 8'hFF); dw(); dw(); ctl(1, 2'b00, 0, 8'hFF); dw(); dw(); ctl(0, 2'b10, 0, 8'h00);
    // R2: every reserved code, alone and inside a burst
    for (int k = 1; k < 8; k += 2) drive(1, 1, {k[3:0], 12'h345});
    ctl(1, 2'b00, 1, 8'h21); dw(); drive(1, 1, 16'h5000); dw(); ctl(0, 2'b10, 0, 8'h00);
    // R3: payload control followed by control words
    ctl(1, 2'b00, 1, 8'h21); ctl(0, 2'b00, 0, 8'h00);
    ctl(1, 2'b00, 1, 8'h21); ctl(1, 2'b00, 1, 8'h42); dw(); ctl(0, 2'b10, 0, 8'h00);
    // R4: data after the burst was closed
    dw();
    // R8: abort taints exactly the next packet
    ctl(1, 2'b00, 1, 8'h42); dw(); dw(); ctl(1, 2'b01, 1, 8'h21); dw(); dw();
    ctl(1, 2'b10, 1, 8'h42); dw(); ctl(0, 2'b11, 0, 8'h00);
    // R10: clear alone, then clear against a new event
    drive(0, 0, 16'h0, 0, 0, 0, 0, 1);
    gap();
    ctl(1, 2'b00, 1, 8'h07); dw();
    drive(1, 0, 16'hBEEF, 0, 0, 0, 0, 1);
    ctl(0, 2'b00, 0, 8'h00); gap();
    drive(0, 0, 16'h0, 0, 0, 0, 0, 1);
    // R11: deactivate an entry, a burst already open keeps its lookup
    ctl(1, 2'b00, 1, 8'h21); wr(8'h21, 0, 6'd9); dw(); dw(); ctl(0, 2'b10, 0, 8'h00);
    ctl(1, 2'b00, 1, 8'h21); dw(); ctl(0, 2'b10, 0, 8'h00);
    // R5: new local ID after a rewrite
    wr(8'h21, 1, 6'd33);
    ctl(1, 2'b00, 1, 8'h21); dw(); ctl(0, 2'b10, 0, 8'h00);
    gap(); gap(); gap();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule